// File: doc/BRIEF.md
# Bank-aware flash read-mode tracker

This block sits beside the command interface of a multi-bank flash device and decides, for every bus read, which data source answers it: the memory array, the identification data, or the query table. It watches bus write cycles (address and data) for three kinds of command: a single-write request to enter query mode, a three-write unlock sequence that enters identify mode, and a reset that backs out of the current mode. Each mode is tagged with the bank it was issued to, so reads to any other bank keep returning array data.

Query mode remembers where it came from. When it was entered from identify mode, a reset goes back to identify mode on the same bank, and a second reset is needed to reach array reading. For query-sourced reads the block also hands out a local table index taken from the low address byte. The read-source decision is combinational, valid in the cycle the read strobe is high.

Top module: `flash_rmode_tracker`

## Requirements
- R1: After the asynchronous active-low reset the block is in array mode: every read returns source 2'b00 (array) and a query index of zero, whatever mode was active before the reset.
- R2: A write of data 0x98 at in-bank offset 0x055 (address bits 10:0) from array mode enters query mode for the bank in address bits 22:19; reads to that bank return source 2'b10 (query). Source 2'b11 never appears.
- R3: In query mode, reads to any bank other than the tagged one return source 2'b00.
- R4: For a read with source 2'b10 the query index output equals address bits 7:0; for every other read it is zero.
- R5: The write sequence 0xAA at offset 0x555, 0x55 at offset 0x2AA, 0x90 at offset 0x555, issued in array mode, enters identify mode for the bank of the third write; reads to that bank return 2'b01, other banks 2'b00. A sequence with a wrong data value does not change the mode.
- R6: In identify mode the enter-query write is accepted only when its bank equals the identify bank; with any other bank the mode stays identify on the original bank.
- R7: In query mode a further enter-query write is ignored: the tagged bank and the mode stay unchanged.
- R8: A reset command (data 0xF0 at any address) in query mode entered from array mode returns to array mode.
- R9: A reset command in query mode entered from identify mode returns to identify mode on the earlier bank; a second reset command then returns to array mode.
- R10: A reset command in identify mode returns to array mode; while the read strobe is low the source output is 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write cycle strobe |
| rd_en | input | 1 | Bus read cycle strobe |
| addr | input | ADDR_W (23) | Word address of the current cycle; bits 22:19 select the bank |
| wdata | input | DATA_W (8) | Write data of the current cycle |
| rd_src | output | 2 | Read source: 00 array, 01 identify, 10 query |
| qry_addr | output | QADDR_W (8) | Local query-table index for query-sourced reads, else zero |

## Verification
On every cycle the assertions check that the source code never takes the unused value, that an idle strobe selects the array, that the query index follows the low address byte whenever the query table answers, that reads outside the tagged bank in query mode fall back to the array, and that a repeated enter-query, a mismatched-bank enter-query from identify mode, and a reset from query mode with an identify history each leave the expected mode. Only the bench scenarios show the complete multi-write paths: the unlock sequence and its rejection on wrong data, the two-step reset ladder from query through identify back to array, and the effect of a hardware reset taken in the middle of query mode.

// File: rtl/flash_rmode_pkg.sv
package flash_rmode_pkg;

   typedef enum logic [1:0] {
      MODE_ARRAY = 2'b00,
      MODE_IDENT = 2'b01,
      MODE_QUERY = 2'b10
   } rmode_t;

   typedef struct packed {
      logic go_query;
      logic go_ident;
      logic go_back;
   } cmd_t;

   localparam int unsigned CMD_MIN_W = 11;

   localparam logic [7:0] OP_QUERY   = 8'h98;
   localparam logic [7:0] OP_BACK    = 8'hF0;
   localparam logic [7:0] OP_UNLK_A  = 8'hAA;
   localparam logic [7:0] OP_UNLK_B  = 8'h55;
   localparam logic [7:0] OP_IDENT   = 8'h90;

   localparam logic [10:0] OFF_QUERY = 11'h055;
   localparam logic [10:0] OFF_UNLK1 = 11'h555;
   localparam logic [10:0] OFF_UNLK2 = 11'h2AA;

endpackage

// File: rtl/frt_cmd_decode.sv
module frt_cmd_decode
   import flash_rmode_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CMD_W  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CMD_W-1:0]  cmd_off,
   input  logic [DATA_W-1:0] wdata,
   output cmd_t              cmd
);

   typedef enum logic [1:0] {
      UNLK_IDLE = 2'b00,
      UNLK_ONE  = 2'b01,
      UNLK_TWO  = 2'b10
   } unlk_t;

   unlk_t unlk_q, unlk_d;

   logic hit_a, hit_b, hit_id, hit_q, hit_back;

   always_comb begin
      hit_a    = (wdata == DATA_W'(OP_UNLK_A)) && (cmd_off == CMD_W'(OFF_UNLK1));
      hit_b    = (wdata == DATA_W'(OP_UNLK_B)) && (cmd_off == CMD_W'(OFF_UNLK2));
      hit_id   = (wdata == DATA_W'(OP_IDENT))  && (cmd_off == CMD_W'(OFF_UNLK1));
      hit_q    = (wdata == DATA_W'(OP_QUERY))  && (cmd_off == CMD_W'(OFF_QUERY));
      hit_back = (wdata == DATA_W'(OP_BACK));
   end

   always_comb begin
      unlk_d = unlk_q;
      if (wr_en) begin
         if (hit_a)                          unlk_d = UNLK_ONE;
         else if (unlk_q == UNLK_ONE && hit_b) unlk_d = UNLK_TWO;
         else                                unlk_d = UNLK_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) unlk_q <= UNLK_IDLE;
      else        unlk_q <= unlk_d;
   end

   always_comb begin
      cmd.go_query = wr_en && hit_q;
      cmd.go_ident = wr_en && hit_id && (unlk_q == UNLK_TWO);
      cmd.go_back  = wr_en && hit_back;
   end

endmodule

// File: rtl/frt_mode_fsm.sv
module frt_mode_fsm
   import flash_rmode_pkg::*;
#(
   parameter int unsigned BANK_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cmd_t              cmd,
   input  logic [BANK_W-1:0] wbank,
   output rmode_t            mode,
   output logic [BANK_W-1:0] qbank,
   output logic [BANK_W-1:0] ibank,
   output logic              prev_ident
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode       <= MODE_ARRAY;
         qbank      <= '0;
         ibank      <= '0;
         prev_ident <= 1'b0;
      end else begin
         unique case (mode)
            MODE_ARRAY: begin
               if (cmd.go_ident) begin
                  mode  <= MODE_IDENT;
                  ibank <= wbank;
               end else if (cmd.go_query) begin
                  mode       <= MODE_QUERY;
                  qbank      <= wbank;
                  prev_ident <= 1'b0;
               end
            end
            MODE_IDENT: begin
               if (cmd.go_back) begin
                  mode <= MODE_ARRAY;
               end else if (cmd.go_query && (wbank == ibank)) begin
                  mode       <= MODE_QUERY;
                  qbank      <= wbank;
                  prev_ident <= 1'b1;
               end
            end
            MODE_QUERY: begin
               if (cmd.go_back) mode <= prev_ident ? MODE_IDENT : MODE_ARRAY;
            end
            default: mode <= MODE_ARRAY;
         endcase
      end
   end

endmodule

// File: rtl/frt_read_route.sv
module frt_read_route
   import flash_rmode_pkg::*;
#(
   parameter int unsigned BANK_W  = 4,
   parameter int unsigned QADDR_W = 8
) (
   input  logic               rd_en,
   input  logic [BANK_W-1:0]  rbank,
   input  logic [QADDR_W-1:0] rlow,
   input  rmode_t             mode,
   input  logic [BANK_W-1:0]  qbank,
   input  logic [BANK_W-1:0]  ibank,
   output logic [1:0]         rd_src,
   output logic [QADDR_W-1:0] qry_addr
);

   logic sel_q, sel_i;

   always_comb begin
      sel_q    = rd_en && (mode == MODE_QUERY) && (rbank == qbank);
      sel_i    = rd_en && (mode == MODE_IDENT) && (rbank == ibank);
      rd_src   = sel_q ? MODE_QUERY : (sel_i ? MODE_IDENT : MODE_ARRAY);
      qry_addr = sel_q ? rlow : '0;
   end

endmodule

// File: rtl/flash_rmode_tracker.sv
module flash_rmode_tracker
   import flash_rmode_pkg::*;
#(
   parameter int unsigned ADDR_W   = 23,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned BANK_LSB = 19,
   parameter int unsigned BANK_W   = 4,
   parameter int unsigned CMD_W    = 11,
   parameter int unsigned QADDR_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [1:0]         rd_src,
   output logic [QADDR_W-1:0] qry_addr
);

   localparam int unsigned BANK_MSB = BANK_LSB + BANK_W - 1;

   generate
      if (BANK_MSB >= ADDR_W) begin : g_bad_bank
         $error("bank field exceeds address width");
      end
      if (CMD_W < CMD_MIN_W || CMD_W > BANK_LSB) begin : g_bad_cmd
         $error("command offset width out of range");
      end
      if (QADDR_W > BANK_LSB) begin : g_bad_qaddr
         $error("query index overlaps bank field");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("data width below command opcode width");
      end
   endgenerate

   cmd_t              cmd;
   rmode_t            mode;
   logic [BANK_W-1:0] qbank;
   logic [BANK_W-1:0] ibank;
   logic              prev_ident;
   logic [BANK_W-1:0] abank;

   assign abank = addr[BANK_MSB:BANK_LSB];

   frt_cmd_decode #(.DATA_W(DATA_W), .CMD_W(CMD_W)) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .cmd_off (addr[CMD_W-1:0]),
      .wdata   (wdata),
      .cmd     (cmd)
   );

   frt_mode_fsm #(.BANK_W(BANK_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd        (cmd),
      .wbank      (abank),
      .mode       (mode),
      .qbank      (qbank),
      .ibank      (ibank),
      .prev_ident (prev_ident)
   );

   frt_read_route #(.BANK_W(BANK_W), .QADDR_W(QADDR_W)) u_rt (
      .rd_en    (rd_en),
      .rbank    (abank),
      .rlow     (addr[QADDR_W-1:0]),
      .mode     (mode),
      .qbank    (qbank),
      .ibank    (ibank),
      .rd_src   (rd_src),
      .qry_addr (qry_addr)
   );

endmodule

// File: rtl/frt_checker.sv
module frt_checker #(
   parameter int unsigned ADDR_W   = 23,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned BANK_LSB = 19,
   parameter int unsigned BANK_W   = 4,
   parameter int unsigned CMD_W    = 11,
   parameter int unsigned QADDR_W  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic               rd_en,
   input logic [ADDR_W-1:0]  addr,
   input logic [DATA_W-1:0]  wdata,
   input logic [1:0]         rd_src,
   input logic [QADDR_W-1:0] qry_addr,
   input logic [1:0]         mode,
   input logic [BANK_W-1:0]  qbank,
   input logic [BANK_W-1:0]  ibank,
   input logic               prev_ident
);

   logic [BANK_W-1:0] cbank;
   logic              w_query, w_back;
   assign cbank   = addr[BANK_LSB+BANK_W-1:BANK_LSB];
   assign w_query = wr_en && (wdata == DATA_W'(8'h98)) && (addr[CMD_W-1:0] == CMD_W'(11'h055));
   assign w_back  = wr_en && (wdata == DATA_W'(8'hF0));

   p_src_enc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_src != 2'b11);

   p_idle_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> rd_src == 2'b00);

   p_qidx_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_src == 2'b10) |-> qry_addr == addr[QADDR_W-1:0]);

   p_other_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && mode == 2'b10 && cbank != qbank) |-> rd_src == 2'b00);

   p_query_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && w_query) |=> (mode == 2'b10 && $stable(qbank)));

   p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && prev_ident && w_back) |=> mode == 2'b01);

   p_bank_mismatch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && w_query && cbank != ibank) |=> mode == 2'b01);

endmodule

bind flash_rmode_tracker frt_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_LSB(BANK_LSB),
   .BANK_W(BANK_W), .CMD_W(CMD_W), .QADDR_W(QADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .rd_en      (rd_en),
   .addr       (addr),
   .wdata      (wdata),
   .rd_src     (rd_src),
   .qry_addr   (qry_addr),
   .mode       (mode),
   .qbank      (qbank),
   .ibank      (ibank),
   .prev_ident (prev_ident)
);

// File: tb/flash_rmode_tracker_bench.sv
module flash_rmode_tracker_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [22:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [1:0]  rd_src;
   logic [7:0]  qry_addr;

   int unsigned n_chk = 0;
   int unsigned n_bad = 0;
   bit          done = 1'b0;

   logic [9:0]  q_exp[$];
   string       q_tag[$];

   always #2 clk = ~clk;

   flash_rmode_tracker u_flash_rmode_tracker (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rd_src(rd_src), .qry_addr(qry_addr)
   );

   function automatic logic [22:0] mk(input logic [3:0] bank, input logic [18:0] off);
      return {bank, off};
   endfunction

   task automatic idle();
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
   endtask

   task automatic wr(input logic [3:0] bank, input logic [18:0] off, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; rd_en = 1'b0; addr = mk(bank, off); wdata = d;
   endtask

   task automatic chk(input logic [3:0] bank, input logic [18:0] off, input bit rd,
                      input logic [1:0] es, input logic [7:0] eq, input string tag);
      @(negedge clk);
      wr_en = 1'b0; rd_en = rd; addr = mk(bank, off); wdata = 8'h00;
      q_exp.push_back({es, eq});
      q_tag.push_back(tag);
   endtask

   task automatic ident(input logic [3:0] bank, input logic [7:0] last);
      wr(bank, 19'h555, 8'hAA);
      wr(bank, 19'h2AA, 8'h55);
      wr(bank, 19'h555, last);
   endtask

   initial begin : monitor
      forever begin
         @(negedge clk);
         #1;
         if (q_exp.size() != 0) begin
            logic [9:0] e;
            string      t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            n_chk++;
            if ({rd_src, qry_addr} !== e) begin
               n_bad++;
               $display("FAIL %s: src=%b idx=%h expected src=%b idx=%h",
                        t, rd_src, qry_addr, e[9:8], e[7:0]);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(4'd3, 19'h12, 1, 2'b00, 8'h00, "R1 reset array");
      // R2 enter query on bank 5
      wr(4'd5, 19'h055, 8'h98);
      chk(4'd5, 19'h1A, 1, 2'b10, 8'h1A, "R2 query bank");
      chk(4'd5, 19'hFF, 1, 2'b10, 8'hFF, "R4 query index");
      chk(4'd2, 19'h1A, 1, 2'b00, 8'h00, "R3 other bank");
      chk(4'd5, 19'h1A, 0, 2'b00, 8'h00, "R10 idle strobe");
      // R7 second enter-query ignored
      wr(4'd7, 19'h055, 8'h98);
      chk(4'd7, 19'h20, 1, 2'b00, 8'h00, "R7 new bank ignored");
      chk(4'd5, 19'h20, 1, 2'b10, 8'h20, "R7 old bank kept");
      // R8 reset back to array
      wr(4'd9, 19'h123, 8'hF0);
      chk(4'd5, 19'h20, 1, 2'b00, 8'h00, "R8 back to array");
      // R5 broken unlock sequence
      ident(4'd1, 8'h91);
      chk(4'd1, 19'h00, 1, 2'b00, 8'h00, "R5 broken sequence");
      // R5 valid identify on bank 1
      ident(4'd1, 8'h90);
      chk(4'd1, 19'h01, 1, 2'b01, 8'h00, "R5 identify bank");
      chk(4'd4, 19'h01, 1, 2'b00, 8'h00, "R5 other bank");
      // R6 mismatched bank
      wr(4'd4, 19'h055, 8'h98);
      chk(4'd4, 19'h10, 1, 2'b00, 8'h00, "R6 mismatch no query");
      chk(4'd1, 19'h10, 1, 2'b01, 8'h00, "R6 identify kept");
      // R6 matching bank
      wr(4'd1, 19'h055, 8'h98);
      chk(4'd1, 19'h33, 1, 2'b10, 8'h33, "R6 query from identify");
      // R9 reset ladder
      wr(4'd0, 19'h000, 8'hF0);
      chk(4'd1, 19'h33, 1, 2'b01, 8'h00, "R9 first reset identify");
      wr(4'd0, 19'h000, 8'hF0);
      chk(4'd1, 19'h33, 1, 2'b00, 8'h00, "R9 second reset array");
      // R10 reset from identify
      ident(4'd2, 8'h90);
      chk(4'd2, 19'h05, 1, 2'b01, 8'h00, "R10 identify set");
      wr(4'd6, 19'h7, 8'hF0);
      chk(4'd2, 19'h05, 1, 2'b00, 8'h00, "R10 reset to array");
      // R1 hardware reset in query mode
      wr(4'd8, 19'h055, 8'h98);
      chk(4'd8, 19'h44, 1, 2'b10, 8'h44, "R2 query bank 8");
      idle();
      rst_n = 1'b0;
      idle();
      rst_n = 1'b1;
      chk(4'd8, 19'h44, 1, 2'b00, 8'h00, "R1 hw reset clears query");
      idle();
      idle();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule